// File: doc/BRIEF.md
# Colour Palette Lookup with Sequential Entry Loading

This block turns an 8-bit pixel index into an 18-bit colour, with 6 bits each for red, green and blue. It holds 256 colour entries. A host processor fills them through a narrow byte-wide write port. The host first names the entry it wants to load. It then sends the three colour components one after another through a single data address. After each complete colour, the target entry moves on by one, so a whole run of entries can be loaded with one index write followed by a stream of data bytes.

On the pixel side, the incoming index is first ANDed with a host-written mask. The masked value selects an entry, and the colour appears on a registered output one clock later. A new entry becomes visible only once its last component has arrived, so the pixel path never shows a colour that is only half written.

Top module: `palette_lut`

## Requirements
- R1: After reset:
  - the mask is 0xFF;
  - the load pointer is entry 0;
  - the next data byte is taken as red;
  - every entry holds zero;
  - `rgb_out` is zero.
- R2: The host selects a register with `cpu_sel`:
  - 2'b00 writes the mask;
  - 2'b01 writes the load pointer;
  - 2'b10 writes colour data.

  Data bytes are taken as red, then green, then blue. Only bits [5:0] of each data byte are kept. The entry is stored as red in [17:12], green in [11:6] and blue in [5:0].
- R3: An entry keeps its previous colour while only its red and green bytes have been written. It changes on the blue write alone.
- R4: Each blue write advances the load pointer by one, so the next triple goes to the following entry.
- R5: The load pointer advances from 255 to 0.
- R6: Writing the load pointer returns the component sequence to red. A partially sent colour is then discarded.
- R7: The lookup uses `pix_idx & mask`. A mask of 0xFF passes the index unchanged.
- R8: `rgb_out` shows the entry selected by the `pix_idx` sampled at a rising edge. It changes only at that edge, one cycle after the index is applied.
- R9: Writes with `cpu_we` low, or with `cpu_sel` = 2'b11, change nothing.
- R10: A mask write between two data bytes leaves the component sequence and the load pointer where they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_we | input | 1 | Host write strobe |
| cpu_sel | input | 2 | Host register select |
| cpu_wdata | input | 8 | Host write byte |
| pix_idx | input | 8 | Pixel index |
| rgb_out | output | 18 | Looked-up colour, registered |

## Verification
A host write is sampled at the rising edge where `cpu_we` is high, and any entry it completes is in storage after that edge. A lookup index applied before an edge produces its colour on `rgb_out` at that edge. The bench therefore drives every input at a falling edge and reads `rgb_out` at the following falling edge, exactly one rising edge later.

The one-cycle timing is also probed from the other side. The index is changed and `rgb_out` is read again before the next rising edge, to confirm that it has not moved yet. Partial loads are checked by looking up an entry between its green and blue writes.

// File: rtl/palette_lut.sv
module palette_lut #(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 6,
  parameter int BYTE_W = 8,
  localparam int DEPTH   = 1 << IDX_W,
  localparam int ENTRY_W = 3 * COMP_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_we,
  input  logic [1:0]         cpu_sel,
  input  logic [BYTE_W-1:0]  cpu_wdata,
  input  logic [IDX_W-1:0]   pix_idx,
  output logic [ENTRY_W-1:0] rgb_out
);

  localparam logic [1:0] SEL_MASK = 2'b00;
  localparam logic [1:0] SEL_PTR  = 2'b01;
  localparam logic [1:0] SEL_DATA = 2'b10;

  typedef enum logic [1:0] {PH_RED, PH_GRN, PH_BLU} phase_t;

  phase_t              phase;
  logic [IDX_W-1:0]    wr_ptr;
  logic [IDX_W-1:0]    mask_q;
  logic [COMP_W-1:0]   red_q, grn_q;
  logic [ENTRY_W-1:0]  pal [DEPTH];

  wire [COMP_W-1:0] comp     = cpu_wdata[COMP_W-1:0];
  wire              wr_mask  = cpu_we && cpu_sel == SEL_MASK;
  wire              wr_ptr_s = cpu_we && cpu_sel == SEL_PTR;
  wire              wr_data  = cpu_we && cpu_sel == SEL_DATA;
  wire              commit   = wr_data && phase == PH_BLU;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_RED;
      wr_ptr <= '0;
      mask_q <= '1;
      red_q  <= '0;
      grn_q  <= '0;
    end else begin
      if (wr_mask) mask_q <= cpu_wdata[IDX_W-1:0];
      if (wr_ptr_s) begin
        wr_ptr <= cpu_wdata[IDX_W-1:0];
        phase  <= PH_RED;
      end else if (wr_data) begin
        unique case (phase)
          PH_RED: begin red_q <= comp; phase <= PH_GRN; end
          PH_GRN: begin grn_q <= comp; phase <= PH_BLU; end
          default: begin
            phase  <= PH_RED;
            wr_ptr <= wr_ptr + 1'b1;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) pal[i] <= '0;
    end else if (commit) begin
      pal[wr_ptr] <= {red_q, grn_q, comp};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rgb_out <= '0;
    else        rgb_out <= pal[pix_idx & mask_q];
  end

  AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    phase != 2'b11); // R2
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && !wr_ptr_s && phase == PH_BLU) |=> wr_ptr == $past(wr_ptr) + 1'b1); // R4
  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ptr_s |=> (phase == PH_RED && wr_ptr == $past(cpu_wdata[IDX_W-1:0]))); // R6
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ptr_s && !(wr_data && phase == PH_BLU)) |=> $stable(wr_ptr)); // R3
  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask |=> mask_q == $past(cpu_wdata[IDX_W-1:0])); // R7
  AST_PHASE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_data && !wr_ptr_s) |=> $stable(phase)); // R10

endmodule

// File: tb/palette_lut_bench.sv
module palette_lut_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cpu_we = 0;
  logic [1:0]  cpu_sel = 0;
  logic [7:0]  cpu_wdata = 0;
  logic [7:0]  pix_idx = 0;
  logic [17:0] rgb_out;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  palette_lut u_palette_lut (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_sel(cpu_sel),
    .cpu_wdata(cpu_wdata), .pix_idx(pix_idx), .rgb_out(rgb_out)
  );

  function automatic logic [17:0] ent(input logic [7:0] r, input logic [7:0] g, input logic [7:0] b);
    return {r[5:0], g[5:0], b[5:0]};
  endfunction

  task automatic check(input string req, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    cpu_we = 1; cpu_sel = sel; cpu_wdata = d;
    @(negedge clk);
    cpu_we = 0;
  endtask

  task automatic look(input logic [7:0] idx, input logic [17:0] exp, input string req);
    @(negedge clk);
    pix_idx = idx;
    @(negedge clk);
    check(req, rgb_out, exp);
  endtask

  task automatic t_reset;
    check("R1 reset output", rgb_out, 18'h0);
    @(negedge clk); rst_n = 1;
    look(8'h00, 18'h0, "R1 entry 0 zero");
    look(8'hFF, 18'h0, "R1 entry 255 zero");
    wr(2'b10, 8'h01); wr(2'b10, 8'h02); wr(2'b10, 8'h03);
    look(8'h00, ent(8'h01, 8'h02, 8'h03), "R1 pointer starts at 0 on red");
  endtask

  task automatic t_basic_atomic;
    wr(2'b01, 8'h10);
    wr(2'b10, 8'hC5); wr(2'b10, 8'h3F);
    look(8'h10, 18'h0, "R3 entry unchanged before blue");
    wr(2'b10, 8'h80);
    look(8'h10, ent(8'h05, 8'h3F, 8'h00), "R2 upper bits dropped, order RGB");
  endtask

  task automatic t_autoinc;
    wr(2'b01, 8'h20);
    wr(2'b10, 8'h0A); wr(2'b10, 8'h0B); wr(2'b10, 8'h0C);
    wr(2'b10, 8'h1A); wr(2'b10, 8'h1B); wr(2'b10, 8'h1C);
    look(8'h20, ent(8'h0A, 8'h0B, 8'h0C), "R4 first entry");
    look(8'h21, ent(8'h1A, 8'h1B, 8'h1C), "R4 next entry after increment");
  endtask

  task automatic t_wrap;
    wr(2'b01, 8'hFF);
    wr(2'b10, 8'h2A); wr(2'b10, 8'h2B); wr(2'b10, 8'h2C);
    wr(2'b10, 8'h31); wr(2'b10, 8'h32); wr(2'b10, 8'h33);
    look(8'hFF, ent(8'h2A, 8'h2B, 8'h2C), "R5 entry 255");
    look(8'h00, ent(8'h31, 8'h32, 8'h33), "R5 wrap to entry 0");
  endtask

  task automatic t_phase_reset;
    wr(2'b01, 8'h30);
    wr(2'b10, 8'h11);
    wr(2'b01, 8'h40);
    wr(2'b10, 8'h21); wr(2'b10, 8'h22); wr(2'b10, 8'h23);
    look(8'h40, ent(8'h21, 8'h22, 8'h23), "R6 sequence restarts on red");
    look(8'h30, 18'h0, "R6 abandoned entry untouched");
  endtask

  task automatic t_mask;
    wr(2'b00, 8'h1F);
    look(8'hF0, ent(8'h05, 8'h3F, 8'h00), "R7 mask 0x1F maps 0xF0 to 0x10");
    wr(2'b00, 8'h00);
    look(8'hFF, ent(8'h31, 8'h32, 8'h33), "R7 mask 0x00 selects entry 0");
    wr(2'b00, 8'hFF);
    look(8'h21, ent(8'h1A, 8'h1B, 8'h1C), "R7 mask 0xFF passes index");
  endtask

  task automatic t_latency;
    look(8'h10, ent(8'h05, 8'h3F, 8'h00), "R8 first lookup");
    pix_idx = 8'h20;
    #1;
    check("R8 output holds until edge", rgb_out, ent(8'h05, 8'h3F, 8'h00));
    @(negedge clk);
    check("R8 output after one edge", rgb_out, ent(8'h0A, 8'h0B, 8'h0C));
  endtask

  task automatic t_ignored;
    wr(2'b01, 8'h50);
    @(negedge clk); cpu_we = 0; cpu_sel = 2'b10; cpu_wdata = 8'h3F;
    @(negedge clk); cpu_we = 1; cpu_sel = 2'b11; cpu_wdata = 8'h00;
    @(negedge clk); cpu_we = 0;
    look(8'h50, 18'h0, "R9 ignored writes leave entry");
    look(8'h21, ent(8'h1A, 8'h1B, 8'h1C), "R9 mask unchanged by sel 3");
    wr(2'b10, 8'h01); wr(2'b10, 8'h02); wr(2'b10, 8'h04);
    look(8'h50, ent(8'h01, 8'h02, 8'h04), "R9 pointer and phase unchanged");
    look(8'h51, 18'h0, "R9 next entry untouched");
  endtask

  task automatic t_mask_mid;
    wr(2'b01, 8'h60);
    wr(2'b10, 8'h0D);
    wr(2'b00, 8'hFF);
    wr(2'b10, 8'h0E); wr(2'b10, 8'h0F);
    look(8'h60, ent(8'h0D, 8'h0E, 8'h0F), "R10 mask write mid sequence");
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #5;
    t_reset();
    t_basic_atomic();
    t_autoinc();
    t_wrap();
    t_phase_reset();
    t_mask();
    t_latency();
    t_ignored();
    t_mask_mid();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule